// File: doc/BRIEF.md
# Word-Parallel Feedback Shift Buffer

This block is the long memory of a dual-purpose hash and keystream engine. It keeps 32 cells, each eight 32-bit words wide, for 8192 bits in all. On every iteration the whole buffer moves forward by one cell, 256 bits at a time. Two feedback paths run along the way.

The vector fed into the head cell depends on the operating mode. When data is being absorbed, it is the external 8-word input. When output is being squeezed, it is eight words taken from the engine state.

The buffer is built from flip-flops rather than a RAM. This lets the round logic read the cells it needs in the same cycle as a shift, with no port conflicts. The state logic and the iteration sequencing live outside this block. The sequencer raises `shift_en` once per round.

Top module: `fsb_buffer`

## Requirements
- R1: A synchronous active-high `rst` clears all 32 cells to zero, so every tap output reads zero in the cycle after reset.
- R2: While `shift_en` is 0 at a rising edge, every cell keeps its value.
- R3: With `shift_en`=1 and `mode_pull`=0 (absorb mode), cell 0 becomes the old cell 31 XOR `ext_in`. Word k of any 256-bit vector is bits [32k+31:32k].
- R4: With `shift_en`=1 and `mode_pull`=1 (squeeze mode), cell 0 becomes the old cell 31 XOR state words 1 to 8. That is `state_in[287:32]`, where state word k sits at bits [32k+31:32k].
- R5: On a shift, every cell j other than 0 and 25 takes the old value of cell j-1.
- R6: On a shift, word k of cell 25 becomes word k of the old cell 24 XOR word (k+2) mod 8 of the old cell 31.
- R7: `tap_a_o`, `tap_b_o` and `tail_o` show cells 4, 16 and 31 directly from the registers, with no extra delay.
- R8: In squeeze mode `ext_in` has no effect, and in absorb mode `state_in` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| shift_en | input | 1 | Advance the buffer by one cell this edge |
| mode_pull | input | 1 | 0: feed from `ext_in`; 1: feed from state words 1 to 8 |
| ext_in | input | 256 | External 8-word input block |
| state_in | input | 544 | Full 17-word engine state |
| tap_a_o | output | 256 | Contents of cell 4 |
| tap_b_o | output | 256 | Contents of cell 16 |
| tail_o | output | 256 | Contents of cell 31 |

## Verification
Each shift takes effect at the rising edge that samples `shift_en`. All three taps therefore show the new contents one edge after the inputs are driven, and the taps themselves add no cycle of delay.

The bench drives inputs on the falling edge and advances its reference model just after the next rising edge. It compares the taps at the following falling edge, so each result is read exactly one cycle after its stimulus.

The directed rotation case relies on this one-cell-per-shift timing. A block pushed once reaches the tail 31 shifts later. Its rotated copy, injected at cell 25 on the next shift, reaches the tail six shifts after that.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

    parameter int WBITS       = 32;
    parameter int NWORDS      = 8;
    parameter int NCELLS      = 32;
    parameter int STATE_WORDS = 17;

    localparam int CELL_BITS  = NWORDS * WBITS;
    localparam int STATE_BITS = STATE_WORDS * WBITS;
    localparam int WIDX       = $clog2(NWORDS);

    typedef logic [WBITS-1:0]                word_t;
    typedef logic [NWORDS-1:0][WBITS-1:0]    cell_t;
    typedef logic [NCELLS-1:0][CELL_BITS-1:0] bank_t;

    typedef enum logic {
        FEED_EXT   = 1'b0,
        FEED_STATE = 1'b1
    } feed_mode_e;

    typedef struct packed {
        logic       advance;
        feed_mode_e mode;
    } step_ctl_t;

    // word k of the result is word (k+amt) mod NWORDS of the source
    function automatic cell_t rot_words(input cell_t src, input int amt);
        cell_t res;
        for (int k = 0; k < NWORDS; k++) begin
            res[k] = src[WIDX'((k + amt) % NWORDS)];
        end
        return res;
    endfunction

endpackage

// File: rtl/fsb_feed_sel.sv
module fsb_feed_sel
    import fsb_pkg::*;
#(
    parameter int FEED_OFF = 1
) (
    input  feed_mode_e              mode,
    input  cell_t                   ext_blk,
    input  logic [STATE_BITS-1:0]   state_vec,
    output cell_t                   fed
);
    localparam int LO = FEED_OFF * WBITS;

    cell_t from_state;

    always_comb begin
        from_state = cell_t'(state_vec[LO +: CELL_BITS]);
        unique case (mode)
            FEED_EXT:   fed = ext_blk;
            FEED_STATE: fed = from_state;
            default:    fed = ext_blk;
        endcase
    end

endmodule

// File: rtl/fsb_next.sv
module fsb_next
    import fsb_pkg::*;
#(
    parameter int MIX_CELL = 25,
    parameter int ROT_AMT  = 2
) (
    input  bank_t cur,
    input  cell_t fed,
    output bank_t nxt
);
    cell_t tail_rot;

    assign tail_rot = rot_words(cell_t'(cur[NCELLS-1]), ROT_AMT);

    for (genvar j = 0; j < NCELLS; j++) begin : g_cell
        if (j == 0) begin : g_head
            assign nxt[j] = cur[NCELLS-1] ^ fed;
        end else if (j == MIX_CELL) begin : g_mix
            assign nxt[j] = cur[j-1] ^ tail_rot;
        end else begin : g_move
            assign nxt[j] = cur[j-1];
        end
    end

endmodule

// File: rtl/fsb_store.sv
module fsb_store
    import fsb_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  bank_t d,
    output bank_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/fsb_buffer.sv
module fsb_buffer
    import fsb_pkg::*;
#(
    parameter int TAP_A    = 4,
    parameter int TAP_B    = 16,
    parameter int MIX_CELL = 25,
    parameter int ROT_AMT  = 2,
    parameter int FEED_OFF = 1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  logic                  mode_pull,
    input  logic [CELL_BITS-1:0]  ext_in,
    input  logic [STATE_BITS-1:0] state_in,
    output logic [CELL_BITS-1:0]  tap_a_o,
    output logic [CELL_BITS-1:0]  tap_b_o,
    output logic [CELL_BITS-1:0]  tail_o
);
    step_ctl_t ctl;
    cell_t     fed;
    bank_t     cells_q;
    bank_t     cells_d;

    assign ctl.advance = shift_en;
    assign ctl.mode    = mode_pull ? FEED_STATE : FEED_EXT;

    fsb_feed_sel #(.FEED_OFF(FEED_OFF)) u_feed (
        .mode      (ctl.mode),
        .ext_blk   (cell_t'(ext_in)),
        .state_vec (state_in),
        .fed       (fed)
    );

    fsb_next #(.MIX_CELL(MIX_CELL), .ROT_AMT(ROT_AMT)) u_next (
        .cur (cells_q),
        .fed (fed),
        .nxt (cells_d)
    );

    fsb_store u_store (
        .clk  (clk),
        .rst  (rst),
        .load (ctl.advance),
        .d    (cells_d),
        .q    (cells_q)
    );

    assign tap_a_o = cells_q[TAP_A];
    assign tap_b_o = cells_q[TAP_B];
    assign tail_o  = cells_q[NCELLS-1];

endmodule

// File: rtl/fsb_chk.sv
module fsb_chk
    import fsb_pkg::*;
(
    input logic                  clk,
    input logic                  rst,
    input logic                  shift_en,
    input logic                  mode_pull,
    input logic [CELL_BITS-1:0]  ext_in,
    input logic [STATE_BITS-1:0] state_in,
    input bank_t                 cells_q,
    input logic [CELL_BITS-1:0]  tap_a_o,
    input logic [CELL_BITS-1:0]  tap_b_o,
    input logic [CELL_BITS-1:0]  tail_o
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cells_q == '0));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> (cells_q == $past(cells_q)));

    // R3
    push_head_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && !mode_pull) |=> (cells_q[0] == $past(cells_q[NCELLS-1] ^ ext_in)));

    // R4
    pull_head_chk: assert property (@(posedge clk) disable iff (rst)
        (shift_en && mode_pull) |=>
        (cells_q[0] == $past(cells_q[NCELLS-1] ^ state_in[CELL_BITS+WBITS-1:WBITS])));

    // R5
    move_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> ((cells_q[1] == $past(cells_q[0])) &&
                      (cells_q[NCELLS-1] == $past(cells_q[NCELLS-2])) &&
                      (cells_q[24] == $past(cells_q[23]))));

    // R6
    mix_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> (cells_q[25] ==
            $past(cells_q[24] ^ {cells_q[NCELLS-1][2*WBITS-1:0],
                                 cells_q[NCELLS-1][CELL_BITS-1:2*WBITS]})));

    // R7
    always_comb begin
        tap_view_chk: assert (rst || ((tap_a_o == cells_q[4]) &&
                                      (tap_b_o == cells_q[16]) &&
                                      (tail_o == cells_q[NCELLS-1])));
    end

endmodule

bind fsb_buffer fsb_chk u_fsb_chk (
    .clk       (clk),
    .rst       (rst),
    .shift_en  (shift_en),
    .mode_pull (mode_pull),
    .ext_in    (ext_in),
    .state_in  (state_in),
    .cells_q   (cells_q),
    .tap_a_o   (tap_a_o),
    .tap_b_o   (tap_b_o),
    .tail_o    (tail_o)
);

// File: tb/fsb_buffer_bench.sv
module fsb_buffer_bench;
    localparam int W  = 32;
    localparam int NW = 8;
    localparam int NC = 32;
    localparam int CB = NW * W;
    localparam int SB = 17 * W;

    logic          clk = 1'b0;
    logic          rst;
    logic          shift_en;
    logic          mode_pull;
    logic [CB-1:0] ext_in;
    logic [SB-1:0] state_in;
    logic [CB-1:0] tap_a_o, tap_b_o, tail_o;

    logic [NC-1:0][CB-1:0] model;
    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    fsb_buffer u_fsb_buffer (
        .clk(clk), .rst(rst), .shift_en(shift_en), .mode_pull(mode_pull),
        .ext_in(ext_in), .state_in(state_in),
        .tap_a_o(tap_a_o), .tap_b_o(tap_b_o), .tail_o(tail_o)
    );

    function automatic logic [CB-1:0] rot2(input logic [CB-1:0] v);
        logic [CB-1:0] r;
        for (int k = 0; k < NW; k++) r[k*W +: W] = v[((k + 2) % NW)*W +: W];
        return r;
    endfunction

    function automatic logic [CB-1:0] rnd_blk();
        logic [CB-1:0] r;
        for (int k = 0; k < NW; k++) r[k*W +: W] = $urandom;
        return r;
    endfunction

    function automatic logic [SB-1:0] rnd_state();
        logic [SB-1:0] r;
        for (int k = 0; k < 17; k++) r[k*W +: W] = $urandom;
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [CB-1:0] act, input logic [CB-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic check_taps(input string req);
        check(req, "tap_a", tap_a_o, model[4]);
        check(req, "tap_b", tap_b_o, model[16]);
        check(req, "tail",  tail_o,  model[NC-1]);
    endtask

    // one cycle: drive at negedge, model after posedge, compare at next negedge
    task automatic step(input bit en, input bit pull,
                        input logic [CB-1:0] e, input logic [SB-1:0] s);
        logic [NC-1:0][CB-1:0] nm;
        logic [CB-1:0] fedv;
        shift_en = en; mode_pull = pull; ext_in = e; state_in = s;
        @(posedge clk);
        if (en) begin
            fedv = pull ? s[W +: CB] : e;               // R3 / R4 / R8
            for (int j = 1; j < NC; j++) nm[j] = model[j-1];   // R5
            nm[0]  = model[NC-1] ^ fedv;
            nm[25] = model[24] ^ rot2(model[NC-1]);     // R6
            model  = nm;
        end
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [CB-1:0] p;
        void'($urandom(32'h5eed_0042));
        rst = 1'b1; shift_en = 1'b1; mode_pull = 1'b0;
        ext_in = '1; state_in = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        // R1: all taps zero after reset
        check_taps("R1");

        // R2: no shift, inputs busy
        step(0, 0, rnd_blk(), rnd_state());
        check_taps("R2");

        // directed R5/R6: one block travels to the tail, then its rotation follows
        p = rnd_blk();
        step(1, 0, p, rnd_state());
        for (int i = 0; i < 31; i++) step(1, 0, '0, rnd_state());
        check("R5", "tail after 31 moves", tail_o, p);
        step(1, 0, '0, rnd_state());
        for (int i = 0; i < 6; i++) step(1, 0, '0, rnd_state());
        check("R6", "rotated block at tail", tail_o, rot2(p));
        check_taps("R5");

        // R8: squeeze with ext busy, absorb with state busy
        step(1, 1, rnd_blk(), rnd_state());
        check_taps("R4/R8");
        step(1, 0, rnd_blk(), rnd_state());
        check_taps("R3/R8");

        // random mix, R3 R4 R5 R6 R7
        for (int i = 0; i < 400; i++) begin
            bit en;
            bit pl;
            en = ($urandom % 4) != 0;
            pl = $urandom % 2;
            step(en, pl, rnd_blk(), rnd_state());
            check_taps(en ? (pl ? "R4" : "R3") : "R2");
        end
        check("R7", "tail direct", tail_o, model[NC-1]);

        // R1 again mid-run
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model = '0;
        check_taps("R1");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule